// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Parity

The block sends asynchronous serial frames from a one-word holding register through a hidden shift register. Software writes up to nine data bits into the holding register. The empty flag then clears. The holding register can be refilled while the previous word is still going out on the line. When a frame ends and a word is waiting, that word moves into the shifter on the same bit-rate tick, and the empty flag sets again. The empty flag, gated by an interrupt enable, forms the interrupt request.

Each frame is one low start bit, then a data field sent least significant bit first, then one high stop bit. Every bit lasts one bit-rate tick period. The field is 8 or 9 bits wide. When parity is enabled, the top bit of the field holds the parity bit and carries no data. Parity can be even or odd. The output pin is driven either push-pull or open-drain. Open-drain drive lets several transmitters share one wire.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset the empty flag is 1, the line is 1, the shifter is idle, and the output-enable is 0 while transmit enable is 0.
- R2: A frame starts on a bit tick where the shifter is idle or ending its stop bit, transmit enable is 1 and a word is pending. The frame is start bit 0, then the field LSB first, then stop bit 1, and each bit is held from one tick to the next. When idle, the line is 1.
- R3: The field width depends on the format. Long=0 with parity off sends data bits 0..7. Long=0 with parity on sends data bits 0..6 plus parity. Long=1 with parity off sends data bits 0..8. Long=1 with parity on sends data bits 0..7 plus parity. A frame is therefore 10 bits when long=0 and 11 bits when long=1.
- R4: The parity bit is the last field bit. With par_odd_i=0 the data bits plus parity hold an even number of ones. With par_odd_i=1 they hold an odd number of ones.
- R5: A write clears the empty flag on the next cycle. A second write before the word is taken replaces the pending word, and only the last word is sent.
- R6: The tick that loads a word into the shifter sets the empty flag. A word written during a frame starts, with its start bit, on the tick that ends the current stop bit, with no idle bit in between.
- R7: Clearing transmit enable during a frame lets that frame finish unchanged. While transmit enable is 0, no pending word is loaded, the line stays 1 and the empty flag stays 0.
- R8: In push-pull mode (open_drain_i=0), tx_oe_o is 1 while transmit enable is 1 or a frame is in progress, and 0 otherwise.
- R9: In open-drain mode (open_drain_i=1), tx_oe_o is 1 only while a frame is driving a 0. A 1 is produced by releasing the line, and tx_o then reads 1.
- R10: irq_o equals the empty flag ANDed with irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 9 | Word to send |
| tx_en_i | input | 1 | Transmit enable |
| long_frame_i | input | 1 | 1 selects a 9-bit field, 0 an 8-bit field |
| par_en_i | input | 1 | Parity enable |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even parity |
| open_drain_i | input | 1 | 1 selects open-drain drive |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| irq_en_i | input | 1 | Interrupt enable |
| tx_o | output | 1 | Serial line level |
| tx_oe_o | output | 1 | Pin output-enable |
| empty_o | output | 1 | Holding register empty |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that bit_tick_i is a single-cycle pulse and that the format inputs stay still from a load until the frame's last tick. The bench drives writes and control changes only on cycles away from tick pulses, and changes the format only while the shifter is idle. Under these rules a write never coincides with a load, and each captured frame reflects one fixed format. The bench sweeps all 512 data words under each of the four format settings. It then runs directed sequences for overwrite, back-to-back frames, disabling the transmitter mid-frame, and open-drain drive.

// File: rtl/dbuf_tx_pkg.sv
package dbuf_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic long_frame;
    logic par_en;
    logic par_odd;
  } fmt_t;

  function automatic logic [CNT_W-1:0] frame_len(fmt_t f);
    return f.long_frame ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
  endfunction

  // {stop, field, start}; positions past the field are stop level
  function automatic logic [FRAME_W-1:0] build_frame(logic [DATA_W-1:0] d, fmt_t f);
    logic [DATA_W-1:0] fld;
    logic acc;
    int fw;
    fw  = f.long_frame ? DATA_W : DATA_W - 1;
    acc = f.par_odd;
    fld = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i >= fw) begin
        fld[i] = 1'b1;
      end else if (f.par_en && (i == fw - 1)) begin
        fld[i] = acc;
      end else begin
        fld[i] = d[i];
        acc    = acc ^ d[i];
      end
    end
    return {1'b1, fld, 1'b0};
  endfunction
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  logic [W-1:0] data_q;
  logic         empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr_en_i) begin
      // write wins over a same-cycle take: new word stays pending
      data_q  <= wr_data_i;
      empty_q <= 1'b0;
    end else if (take_i) begin
      empty_q <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
  import dbuf_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              tx_en_i,
  input  logic              pending_i,
  input  logic [DATA_W-1:0] data_i,
  input  fmt_t              fmt_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              line_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;
  logic               last_bit;

  assign last_bit = (left_q == CNT_W'(1));
  assign take_o   = bit_tick_i && tx_en_i && pending_i && (!busy_q || last_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (take_o) begin
      sh_q   <= build_frame(data_i, fmt_i);
      left_q <= frame_len(fmt_i);
      busy_q <= 1'b1;
    end else if (bit_tick_i && busy_q) begin
      if (last_bit) begin
        sh_q   <= '1;
        left_q <= '0;
        busy_q <= 1'b0;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/tx_pin_drv.sv
module tx_pin_drv (
  input  logic line_i,
  input  logic drive_i,
  input  logic open_drain_i,
  output logic tx_o,
  output logic oe_o
);
  // open drain: only a 0 is driven, a 1 is left to the pull-up
  assign oe_o = drive_i && (!open_drain_i || !line_i);
  assign tx_o = line_i;
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbuf_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              long_frame_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              open_drain_i,
  input  logic              bit_tick_i,
  input  logic              irq_en_i,
  output logic              tx_o,
  output logic              tx_oe_o,
  output logic              empty_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] hold_data;
  logic              empty;
  logic              take;
  logic              busy;
  logic              line;
  fmt_t              fmt;

  assign fmt = '{long_frame: long_frame_i, par_en: par_en_i, par_odd: par_odd_i};

  tx_hold_reg #(.W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .data_o    (hold_data),
    .empty_o   (empty)
  );

  tx_frame_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .tx_en_i    (tx_en_i),
    .pending_i  (!empty),
    .data_i     (hold_data),
    .fmt_i      (fmt),
    .take_o     (take),
    .busy_o     (busy),
    .line_o     (line)
  );

  tx_pin_drv u_pin (
    .line_i       (line),
    .drive_i      (tx_en_i || busy),
    .open_drain_i (open_drain_i),
    .tx_o         (tx_o),
    .oe_o         (tx_oe_o)
  );

  assign empty_o = empty;
  assign irq_o   = empty && irq_en_i;
endmodule

// File: rtl/dbuf_serial_tx_chk.sv
module dbuf_serial_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic bit_tick_i,
  input logic open_drain_i,
  input logic busy_i,
  input logic tx_o,
  input logic tx_oe_o,
  input logic empty_o
);
  assert_idle_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> tx_o);

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !tx_o);

  assert_tick_paced_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(busy_i));

  assert_wr_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !empty_o);

  assert_empty_on_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> $past(bit_tick_i));

  assert_od_drives_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_drain_i && tx_oe_o) |-> !tx_o);
endmodule

bind dbuf_serial_tx dbuf_serial_tx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .bit_tick_i   (bit_tick_i),
  .open_drain_i (open_drain_i),
  .busy_i       (busy),
  .tx_o         (tx_o),
  .tx_oe_o      (tx_oe_o),
  .empty_o      (empty_o)
);

// File: tb/dbuf_serial_tx_bench.sv
module dbuf_serial_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       tx_en = 1'b0, m = 1'b0, pe = 1'b0, po = 1'b0, od = 1'b0;
  logic       tick = 1'b0, irq_en = 1'b1;
  logic       tx, oe, empty, irq;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  dbuf_serial_tx u_dbuf_serial_tx (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_en_i(tx_en), .long_frame_i(m), .par_en_i(pe), .par_odd_i(po),
    .open_drain_i(od), .bit_tick_i(tick), .irq_en_i(irq_en),
    .tx_o(tx), .tx_oe_o(oe), .empty_o(empty), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_wr(input logic [8:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  function automatic int flen(input bit lm);
    return lm ? 11 : 10;
  endfunction

  function automatic logic [10:0] exp_frame(input logic [8:0] d, input bit lm, input bit p_en, input bit p_odd);
    logic [10:0] f;
    int nd, ones;
    f = '1; f[0] = 1'b0; ones = 0;
    nd = (lm ? 9 : 8) - (p_en ? 1 : 0);
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    if (p_en) f[nd+1] = p_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
    return f;
  endfunction

  // first tick loads; optional write right after the start bit
  task automatic get_frame(input int n, input bit wr_mid, input logic [8:0] nd,
                           output logic [10:0] bits, output logic e0);
    bits = '1;
    do_tick();
    bits[0] = tx; e0 = empty;
    chk(oe == (od ? !tx : 1'b1), "R8 R9 oe", {31'd0, oe}, {31'd0, od ? !tx : 1'b1});
    if (wr_mid) do_wr(nd);
    for (int i = 1; i < n; i++) begin
      do_tick();
      bits[i] = tx;
      chk(oe == (od ? !tx : 1'b1), "R8 R9 oe", {31'd0, oe}, {31'd0, od ? !tx : 1'b1});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [10:0] bits, bits2, ef;
    logic        e0;
    int          n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(empty == 1'b1, "R1 empty", {31'd0, empty}, 32'd1);
    chk(tx == 1'b1,    "R1 line",  {31'd0, tx}, 32'd1);
    chk(oe == 1'b0,    "R1 oe",    {31'd0, oe}, 32'd0);
    // R10 irq gating
    chk(irq == 1'b1,   "R10 irq en", {31'd0, irq}, 32'd1);
    irq_en = 1'b0; @(negedge clk);
    chk(irq == 1'b0,   "R10 irq dis", {31'd0, irq}, 32'd0);
    irq_en = 1'b1;

    // R5 overwrite while disabled; R7 no load when disabled
    do_wr(9'h0A5);
    chk(empty == 1'b0 && irq == 1'b0, "R5 R10 after write", {30'd0, empty, irq}, 32'd0);
    do_wr(9'h13C);
    repeat (3) do_tick();
    chk(tx == 1'b1 && empty == 1'b0, "R7 held while disabled", {30'd0, tx, empty}, 32'd2);
    chk(oe == 1'b0, "R8 oe idle disabled", {31'd0, oe}, 32'd0);
    tx_en = 1'b1; m = 1'b1; pe = 1'b0;
    @(negedge clk);
    chk(oe == 1'b1, "R8 oe enabled idle", {31'd0, oe}, 32'd1);
    get_frame(11, 1'b0, 9'h0, bits, e0);
    ef = exp_frame(9'h13C, 1'b1, 1'b0, 1'b0);
    chk(bits == ef, "R5 last word sent", {21'd0, bits}, {21'd0, ef});
    do_tick();

    // R2 R3 R4 R6 exhaustive sweep over data and format
    for (int f = 0; f < 4; f++) begin
      m = f[1]; pe = f[0];
      for (int pp = 0; pp < 2; pp++) begin
        po = pp[0];
        for (int d = (pp == 0 ? 0 : 1); d < 512; d += (pp == 0 ? 1 : 37)) begin
          do_wr(9'(d));
          n = flen(m);
          get_frame(n, 1'b0, 9'h0, bits, e0);
          ef = exp_frame(9'(d), m, pe, po);
          chk(bits == ef, "R2 R3 R4 frame", {21'd0, bits}, {21'd0, ef});
          chk(e0 == 1'b1, "R6 empty on load", {31'd0, e0}, 32'd1);
          do_tick();
          chk(tx == 1'b1, "R2 idle after stop", {31'd0, tx}, 32'd1);
        end
      end
    end

    // R6 back-to-back, R3 length via exact restart tick, all formats
    for (int f = 0; f < 4; f++) begin
      m = f[1]; pe = f[0]; po = f[1];
      n = flen(m);
      do_wr(9'h1D2);
      get_frame(n, 1'b1, 9'h04B, bits, e0);
      chk(empty == 1'b0, "R6 pending during frame", {31'd0, empty}, 32'd0);
      ef = exp_frame(9'h1D2, m, pe, po);
      chk(bits == ef, "R6 first frame", {21'd0, bits}, {21'd0, ef});
      get_frame(n, 1'b0, 9'h0, bits2, e0);
      chk(e0 == 1'b1, "R6 empty at handover", {31'd0, e0}, 32'd1);
      ef = exp_frame(9'h04B, m, pe, po);
      chk(bits2 == ef, "R3 R6 second frame no gap", {21'd0, bits2}, {21'd0, ef});
      do_tick();
    end

    // R7 disable mid-frame
    m = 1'b1; pe = 1'b1; po = 1'b0;
    do_wr(9'h0F3);
    do_tick();
    chk(tx == 1'b0, "R7 start bit", {31'd0, tx}, 32'd0);
    do_wr(9'h155);
    tx_en = 1'b0;
    bits = '1; bits[0] = 1'b0;
    for (int i = 1; i < 11; i++) begin
      do_tick();
      bits[i] = tx;
      chk(oe == 1'b1, "R8 oe while finishing", {31'd0, oe}, 32'd1);
    end
    ef = exp_frame(9'h0F3, 1'b1, 1'b1, 1'b0);
    chk(bits == ef, "R7 frame completes", {21'd0, bits}, {21'd0, ef});
    do_tick();
    chk(tx == 1'b1 && empty == 1'b0 && oe == 1'b0, "R7 R8 stopped, word kept",
        {29'd0, tx, empty, oe}, 32'd4);
    tx_en = 1'b1;
    get_frame(11, 1'b0, 9'h0, bits, e0);
    ef = exp_frame(9'h155, 1'b1, 1'b1, 1'b0);
    chk(bits == ef, "R7 kept word sent", {21'd0, bits}, {21'd0, ef});
    do_tick();

    // R9 open drain
    od = 1'b1; m = 1'b0; pe = 1'b1; po = 1'b1;
    @(negedge clk);
    chk(oe == 1'b0 && tx == 1'b1, "R9 idle released", {30'd0, oe, tx}, 32'd1);
    do_wr(9'h05A);
    get_frame(10, 1'b0, 9'h0, bits, e0);
    ef = exp_frame(9'h05A, 1'b0, 1'b1, 1'b1);
    chk(bits == ef, "R9 open drain frame", {21'd0, bits}, {21'd0, ef});
    do_tick();
    chk(oe == 1'b0, "R9 released after stop", {31'd0, oe}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule